// File: doc/BRIEF.md
# Reset-Time Link Width Negotiator

This block settles the transmit and receive width of one direction of a narrow point-to-point chip link. It serves both cold and warm link resets. While a cold link reset is held and the control line stays low, the block drives its own receiver capability onto the low command/address/data lanes. At the same time it captures the code the peer drives back. When the link reset is released, the block settles the widest width that both ends can handle. The legal widths are 2, 4, 8 and 16 lanes.

Software can later ask for different widths, and for a different link clock, through a small register write port. Such requests are only staged. They become active on a later qualifying event: the release of a warm link reset, or a reconnect after a stop-signal disconnect. A cold reset returns the clock selection to its power-up value, which is the 200 MHz setting with code 0. Downstream logic uses the active width codes, the transmit lane-enable mask and the clock selection to configure the serialisers and the clock generator.

Top module: `lnk_width_neg`

## Requirements
- R1: While `cold_rst_n` is low, and after it rises until the first link-reset release, `tx_wcode` and `rx_wcode` read 0 (2 lanes) and `freq_sel` reads 0 (200 MHz).
- R2: During the cold phase, the peer code on `cad_in[2:0]` is captured on every clock edge where `link_rst_n` is low and `ctl_in` is low. Edges with `ctl_in` high leave the captured code unchanged.
- R3: On the clock edge after `link_rst_n` rises at the end of a cold reset, `tx_wcode` becomes the smaller of `TX_CAP` and the decoded peer code. The decoding is 000=2, 001=4, 010=8 and 011=16 lanes. Any code with bit 2 set is treated as 2 lanes, and so is an all-zero (undriven) code.
- R4: At that same edge, `rx_wcode` becomes the smaller of `RX_CAP` and the decoded peer code.
- R5: `tx_lane_en` has exactly the lowest 2<<`tx_wcode` bits set.
- R6: A register write never changes `tx_wcode`, `rx_wcode` or `freq_sel` by itself. These outputs move only on a link-reset release or a stop reconnect.
- R7: On the release of a warm link reset (any link reset after the first), the staged width and clock values become active. The lane code the peer drives during that reset is ignored.
- R8: A rising edge of `stop_n`, seen while `link_rst_n` is high and outside the cold phase, makes the staged values active on the following clock edge.
- R9: A write with `reg_sel`=1 stages `reg_wdata[3:0]` as the clock selection. A cold reset restores selection 0.
- R10: `cad_adv` drives `RX_CAP` as a 3-bit code while `link_rst_n` is low, and 000 otherwise.
- R11: A write with `reg_sel`=0 stages the transmit code from `reg_wdata[1:0]` and the receive code from `reg_wdata[3:2]`. Each is clamped to `TX_CAP` or `RX_CAP` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| cold_rst_n | input | 1 | Asynchronous cold (power-on) reset, active low |
| link_rst_n | input | 1 | Link reset level, active low |
| ctl_in | input | 1 | Control line from the peer |
| cad_in | input | 3 | Lanes 0 to 2 from the peer, carrying its receiver code during reset |
| stop_n | input | 1 | Stop request, active low; its rising edge is a reconnect |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects width register, 1 selects clock register |
| reg_wdata | input | 4 | Register write data |
| cad_adv | output | 3 | Local receiver code driven toward the peer |
| tx_wcode | output | 2 | Active transmit width code |
| rx_wcode | output | 2 | Active receive width code |
| tx_lane_en | output | 16 | Enable mask for driven transmit lanes |
| freq_sel | output | 4 | Active link clock selection |

## Verification
The bench covers peer codes above, equal to and below each capability, as well as an invalid code with bit 2 set and an all-zero code. A design that decoded bit 2 as a real width, or that failed to take the minimum, would settle on a lane count that one side cannot support. Another sequence raises `ctl_in` late in the cold reset while presenting a different code. A sampler that ignored the control line would pick up that late code. The bench also drives a fresh peer code during a warm reset, and checks that writes stay inert until a warm release or a stop reconnect. A design that applied writes at once, or renegotiated on warm reset, would show the wrong width or clock too early. Clamping of oversized software codes is also checked.

// File: rtl/lwn_pkg.sv
package lwn_pkg;
  typedef logic [1:0] wcode_t;
  localparam int ADV_W   = 3;
  localparam int MAX_LN  = 16;
  localparam int FREQ_W  = 4;
  localparam int REG_W   = 4;

  // bit 2 set marks an illegal code; it falls back to the narrowest width
  function automatic wcode_t decode_adv(input logic [ADV_W-1:0] raw);
    return raw[2] ? 2'd0 : raw[1:0];
  endfunction

  function automatic wcode_t narrower(input wcode_t a, input wcode_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [MAX_LN-1:0] lane_mask(input wcode_t c);
    logic [MAX_LN:0] ones;
    ones = (1 << (2 << c)) - 1;
    return ones[MAX_LN-1:0];
  endfunction
endpackage

// File: rtl/lwn_adv_sampler.sv
module lwn_adv_sampler
  import lwn_pkg::*;
(
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             link_rst_n,
  input  logic             ctl_in,
  input  logic [ADV_W-1:0] cad_in,
  output wcode_t           peer_code,
  output logic             in_cold,
  output logic             cold_rel,
  output logic             warm_rel
);
  logic             link_q;
  logic             cold_ph;
  logic [ADV_W-1:0] adv_q;
  logic             rel;

  assign rel = link_rst_n & ~link_q;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      link_q  <= 1'b0;
      cold_ph <= 1'b1;
      adv_q   <= '0;
    end else begin
      link_q <= link_rst_n;
      if (rel) cold_ph <= 1'b0;
      if (cold_ph && !link_rst_n && !ctl_in) adv_q <= cad_in;
    end
  end

  assign peer_code = decode_adv(adv_q);
  assign in_cold   = cold_ph;
  assign cold_rel  = rel & cold_ph;
  assign warm_rel  = rel & ~cold_ph;
endmodule

// File: rtl/lwn_stop_detect.sv
module lwn_stop_detect (
  input  logic clk,
  input  logic cold_rst_n,
  input  logic stop_n,
  input  logic link_rst_n,
  input  logic in_cold,
  output logic reconnect
);
  logic stop_q;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) stop_q <= 1'b1;
    else             stop_q <= stop_n;
  end

  assign reconnect = stop_n & ~stop_q & link_rst_n & ~in_cold;
endmodule

// File: rtl/lwn_cfg_regs.sv
module lwn_cfg_regs
  import lwn_pkg::*;
#(
  parameter wcode_t TX_CAP = 2'd3,
  parameter wcode_t RX_CAP = 2'd2
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              cold_rel,
  input  logic              apply_evt,
  input  wcode_t            peer_code,
  output wcode_t            act_tx,
  output wcode_t            act_rx,
  output logic [FREQ_W-1:0] act_freq,
  output wcode_t            pend_tx
);
  wcode_t            pend_rx;
  logic [FREQ_W-1:0] pend_freq;
  wcode_t            neg_tx;
  wcode_t            neg_rx;

  assign neg_tx = narrower(peer_code, TX_CAP);
  assign neg_rx = narrower(peer_code, RX_CAP);

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      pend_tx   <= '0;
      pend_rx   <= '0;
      pend_freq <= '0;
      act_tx    <= '0;
      act_rx    <= '0;
      act_freq  <= '0;
    end else begin
      if (reg_we && !reg_sel) begin
        pend_tx <= narrower(reg_wdata[1:0], TX_CAP);
        pend_rx <= narrower(reg_wdata[3:2], RX_CAP);
      end
      if (reg_we && reg_sel) pend_freq <= reg_wdata[FREQ_W-1:0];
      if (cold_rel) begin
        pend_tx <= neg_tx;
        pend_rx <= neg_rx;
        act_tx  <= neg_tx;
        act_rx  <= neg_rx;
      end
      if (apply_evt) begin
        act_tx   <= pend_tx;
        act_rx   <= pend_rx;
        act_freq <= pend_freq;
      end
    end
  end
endmodule

// File: rtl/lnk_width_neg.sv
module lnk_width_neg
  import lwn_pkg::*;
#(
  parameter wcode_t TX_CAP = 2'd3,
  parameter wcode_t RX_CAP = 2'd2
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              link_rst_n,
  input  logic              ctl_in,
  input  logic [ADV_W-1:0]  cad_in,
  input  logic              stop_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [ADV_W-1:0]  cad_adv,
  output logic [1:0]        tx_wcode,
  output logic [1:0]        rx_wcode,
  output logic [MAX_LN-1:0] tx_lane_en,
  output logic [FREQ_W-1:0] freq_sel
);
  wcode_t peer_code;
  wcode_t pend_tx;
  logic   in_cold;
  logic   cold_rel;
  logic   warm_rel;
  logic   reconnect;
  logic   apply_evt;

  lwn_adv_sampler u_samp (
    .clk(clk), .cold_rst_n(cold_rst_n), .link_rst_n(link_rst_n),
    .ctl_in(ctl_in), .cad_in(cad_in), .peer_code(peer_code),
    .in_cold(in_cold), .cold_rel(cold_rel), .warm_rel(warm_rel)
  );

  lwn_stop_detect u_stop (
    .clk(clk), .cold_rst_n(cold_rst_n), .stop_n(stop_n),
    .link_rst_n(link_rst_n), .in_cold(in_cold), .reconnect(reconnect)
  );

  assign apply_evt = warm_rel | reconnect;

  lwn_cfg_regs #(.TX_CAP(TX_CAP), .RX_CAP(RX_CAP)) u_regs (
    .clk(clk), .cold_rst_n(cold_rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cold_rel(cold_rel), .apply_evt(apply_evt),
    .peer_code(peer_code), .act_tx(tx_wcode), .act_rx(rx_wcode),
    .act_freq(freq_sel), .pend_tx(pend_tx)
  );

  assign cad_adv    = link_rst_n ? '0 : {1'b0, RX_CAP};
  assign tx_lane_en = lane_mask(tx_wcode);
endmodule

// File: rtl/lnk_width_neg_chk.sv
module lnk_width_neg_chk #(
  parameter logic [1:0] TX_CAP = 2'd3,
  parameter logic [1:0] RX_CAP = 2'd2
) (
  input logic        clk,
  input logic        cold_rst_n,
  input logic        link_rst_n,
  input logic [1:0]  tx_wcode,
  input logic [1:0]  rx_wcode,
  input logic [15:0] tx_lane_en,
  input logic [2:0]  cad_adv,
  input logic        apply_evt,
  input logic        cold_rel,
  input logic [1:0]  pend_tx
);
  // R6
  width_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !(apply_evt || cold_rel) |=> ($stable(tx_wcode) && $stable(rx_wcode)));

  // R5
  lane_count_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $countones(tx_lane_en) == (32'd2 << tx_wcode));

  // R10
  adv_drive_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !link_rst_n |-> cad_adv == {1'b0, RX_CAP});

  // R3 R4
  cap_limit_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (tx_wcode <= TX_CAP) && (rx_wcode <= RX_CAP));

  // R8
  apply_copy_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    apply_evt |=> tx_wcode == $past(pend_tx));
endmodule

bind lnk_width_neg lnk_width_neg_chk #(.TX_CAP(TX_CAP), .RX_CAP(RX_CAP)) u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .link_rst_n(link_rst_n),
  .tx_wcode(tx_wcode), .rx_wcode(rx_wcode), .tx_lane_en(tx_lane_en),
  .cad_adv(cad_adv), .apply_evt(apply_evt), .cold_rel(cold_rel),
  .pend_tx(pend_tx)
);

// File: tb/lnk_width_neg_bench.sv
module lnk_width_neg_bench;
  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0;
  logic        link_rst_n = 1'b0;
  logic        ctl_in = 1'b0;
  logic [2:0]  cad_in = '0;
  logic        stop_n = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [3:0]  reg_wdata = '0;
  logic [2:0]  cad_adv;
  logic [1:0]  tx_wcode, rx_wcode;
  logic [15:0] tx_lane_en;
  logic [3:0]  freq_sel;

  localparam int TX_BITS = 16;  // default TX_CAP = 3
  localparam int RX_BITS = 8;   // default RX_CAP = 2

  lnk_width_neg u_lnk_width_neg (.*);

  always #4 clk = ~clk;

  typedef struct {
    string      tag;
    int         tx_bits;
    int         rx_bits;
    int         freq;
    logic [2:0] adv;
  } exp_t;

  exp_t sb[$];
  event smp_ev;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  function automatic int peer_bits(input logic [2:0] raw);
    if (raw > 3'd3) return 2;
    return 2 << raw;
  endfunction

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic expect_now(input string tag, input int txb, input int rxb,
                            input int fq, input logic [2:0] adv);
    exp_t e;
    e.tag = tag; e.tx_bits = txb; e.rx_bits = rxb; e.freq = fq; e.adv = adv;
    sb.push_back(e);
    -> smp_ev;
    #1;
  endtask

  // monitor: pops one expected item per sample strobe
  initial begin
    forever begin
      exp_t e;
      int   atx, arx;
      logic [16:0] m;
      @(smp_ev);
      e   = sb.pop_front();
      atx = 2 << tx_wcode;
      arx = 2 << rx_wcode;
      m   = (17'd1 << e.tx_bits) - 17'd1;
      total++;
      if (atx != e.tx_bits || arx != e.rx_bits || int'(freq_sel) != e.freq ||
          cad_adv != e.adv || tx_lane_en != m[15:0]) begin
        bad++;
        $display("FAIL %s: tx=%0d rx=%0d freq=%0d adv=%0d mask=%h expected tx=%0d rx=%0d freq=%0d adv=%0d mask=%h",
                 e.tag, atx, arx, freq_sel, cad_adv, tx_lane_en,
                 e.tx_bits, e.rx_bits, e.freq, e.adv, m[15:0]);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cold_reset(input logic [2:0] code);
    @(negedge clk);
    cold_rst_n = 1'b0; link_rst_n = 1'b0; ctl_in = 1'b0; cad_in = code;
    cycles(2);
    cold_rst_n = 1'b1;
    cycles(3);
  endtask

  task automatic release_link;
    link_rst_n = 1'b1; cad_in = '0; ctl_in = 1'b0;
    cycles(1);
  endtask

  task automatic reg_write(input logic sel, input logic [3:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    cycles(1);
    reg_we = 1'b0;
  endtask

  initial begin
    // R1 R10: state held during cold reset
    cold_reset(3'd3);
    expect_now("R1 R10 cold hold", 2, 2, 0, 3'b010);
    release_link;
    // R3 R4 R5: peer 16 lanes
    expect_now("R3 R4 R5 peer=011", min_i(TX_BITS, peer_bits(3'd3)),
               min_i(RX_BITS, peer_bits(3'd3)), 0, 3'b000);

    cold_reset(3'd1);
    release_link;
    expect_now("R3 R4 peer=001", min_i(TX_BITS, 4), min_i(RX_BITS, 4), 0, 3'b000);

    cold_reset(3'd6);
    release_link;
    expect_now("R3 invalid peer=110", 2, 2, 0, 3'b000);

    cold_reset(3'd0);
    release_link;
    expect_now("R3 zero peer", 2, 2, 0, 3'b000);

    // R2: ctl high later in reset must not replace the captured code
    cold_reset(3'd2);
    ctl_in = 1'b1; cad_in = 3'd3;
    cycles(3);
    expect_now("R2 R10 during ctl high", 2, 2, 0, 3'b010);
    release_link;
    expect_now("R2 ctl gate", 8, 8, 0, 3'b000);

    // R6 R11: staged write, no immediate effect
    reg_write(1'b0, 4'b0001);        // tx code 1 (4), rx code 0 (2)
    cycles(2);
    expect_now("R6 width write staged", 8, 8, 0, 3'b000);

    // R7: warm reset applies; new peer code ignored
    link_rst_n = 1'b0; cad_in = 3'd3; ctl_in = 1'b0;
    cycles(3);
    expect_now("R7 R10 warm hold", 8, 8, 0, 3'b010);
    release_link;
    expect_now("R7 warm apply", 4, 2, 0, 3'b000);

    // R11 R9 R6: oversized rx code clamps; clock staged
    reg_write(1'b0, 4'b1111);
    reg_write(1'b1, 4'd5);
    cycles(1);
    expect_now("R6 R9 freq staged", 4, 2, 0, 3'b000);
    stop_n = 1'b0;
    cycles(3);
    expect_now("R6 R8 while stopped", 4, 2, 0, 3'b000);
    stop_n = 1'b1;
    cycles(1);
    expect_now("R8 R11 reconnect apply", 16, RX_BITS, 5, 3'b000);

    // R7 R9: clock change through warm reset
    reg_write(1'b1, 4'd9);
    link_rst_n = 1'b0;
    cycles(2);
    release_link;
    expect_now("R7 R9 warm freq", 16, 8, 9, 3'b000);

    // R1 R9: cold reset restores defaults
    cold_reset(3'd2);
    expect_now("R1 R9 cold clears", 2, 2, 0, 3'b010);
    release_link;
    expect_now("R3 R4 R9 after cold", 8, 8, 0, 3'b000);

    cycles(2);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule